// File: doc/BRIEF.md
# Programmable Parallel I/O Port

This block is a host-programmable parallel port with three 8-bit pin groups, called A, B and C. Group C is split into a high nibble and a low nibble, and each nibble has its own direction. A host reaches the block through a small asynchronous-style strobe bus. The bus has an active-low select, active-low read and write strobes, a 2-bit register index and an 8-bit data path. Everything is sampled on the block clock. A write commits on the clock edge where the write strobe is seen to rise while select is still low.

Register index 3 takes two commands, and data bit 7 tells them apart. With bit 7 set, the byte is a configuration word: it sets the direction of A, B and each half of C, and it stores the handshake mode fields. Those mode fields are kept and can be read back, but they have no effect on the pins; only plain I/O behaviour is built. With bit 7 clear, the byte changes a single bit of C's output register and leaves every other bit where it was. Pins that are configured as outputs drive the output register value. Pins that are configured as inputs are captured by a sampling register and returned on reads.

Top module: `pio_top`

## Requirements
- R1: While `rst` is high and after it is released, all output registers read 0x00 and all output enables are 0. The configuration reads back as 0x9B, meaning every group is an input and every mode field is zero.
- R2: A committed write to index 0, 1 or 2 loads the data byte into the output register of A, B or C respectively. The register value appears on `pa_out`, `pb_out` or `pc_out`.
- R3: A configuration word (bit 7 = 1) sets the directions, with 1 = input and 0 = output. Bit 4 controls A, bit 3 controls C[7:4], bit 1 controls B and bit 0 controls C[3:0]. The enable bits of each group are all 1 exactly when that group is an output.
- R4: A configuration word clears the output registers of A, B and C to 0x00 on the same edge that applies the new directions.
- R5: A write to index 3 with bit 7 = 0 is a bit command. Bits 3:1 give the C bit number and bit 0 gives its new value. Only that bit of C's output register changes. A, B and the configuration are left untouched.
- R6: A read of A or B returns the sampled pins when that group is an input, and returns its output register when it is an output. The pins reach the read path after `SAMPLE_STAGES` clocks.
- R7: A read of C builds each nibble separately: it uses the sampled pins for a nibble configured as input and the output register for a nibble configured as output.
- R8: A write commits only when `wr_n` rises while `cs_n` is low. A write strobe that rises while `cs_n` is high changes nothing.
- R9: A read of index 3 returns the last configuration word: bit 7 = 1, the A mode in bits 6:5 and the B mode in bit 2. The handshake mode values (A = 01/1x, B = 1) are stored but do not change the pin directions.
- R10: `rdata` is 0x00 whenever `cs_n` or `rd_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Host select, active low |
| rd_n | input | 1 | Host read strobe, active low |
| wr_n | input | 1 | Host write strobe, active low; commits on rising edge |
| addr | input | 2 | Register index: 0 = A, 1 = B, 2 = C, 3 = control |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data |
| pa_in | input | 8 | Group A pin levels |
| pa_out | output | 8 | Group A output register |
| pa_oe | output | 8 | Group A drive enables |
| pb_in | input | 8 | Group B pin levels |
| pb_out | output | 8 | Group B output register |
| pb_oe | output | 8 | Group B drive enables |
| pc_in | input | 8 | Group C pin levels |
| pc_out | output | 8 | Group C output register |
| pc_oe | output | 8 | Group C drive enables (two nibbles) |

## Verification
The properties check several rules on every cycle. Enables stay uniform within each group or nibble. A configuration word always leaves zeroed outputs behind it. A bit command flips at most one bit of C and never touches A or B. No pin state moves unless a strobe rose under select. The read bus is quiet when idle. The bench scenarios are needed for the things a property cannot see. These are the exact bit that a given command selects, the mapping from configuration bits to each group, the nibble-wise merge of C on reads, the sampling latency of input pins, and the readback of stored handshake modes that have no effect.

// File: rtl/pio_pkg.sv
package pio_pkg;

    localparam int PORT_W    = 8;
    localparam int HALF_W    = PORT_W / 2;
    localparam int NPORT     = 3;
    localparam int NREG      = 4;
    localparam int BIT_IDX_W = $clog2(PORT_W);

    typedef enum logic [1:0] {
        SEL_A    = 2'd0,
        SEL_B    = 2'd1,
        SEL_C    = 2'd2,
        SEL_CTRL = 2'd3
    } reg_sel_e;

    // Field order matches the configuration word bits 6..0.
    typedef struct packed {
        logic [1:0] a_mode;
        logic       a_in;
        logic       cu_in;
        logic       b_mode;
        logic       b_in;
        logic       cl_in;
    } port_cfg_t;

    typedef struct packed {
        logic                 en;
        logic [BIT_IDX_W-1:0] idx;
        logic                 val;
    } bit_cmd_t;

    localparam logic [7:0] CFG_RESET_WORD = 8'h9B;

    function automatic port_cfg_t cfg_from_word(input logic [7:0] w);
        port_cfg_t c;
        c.a_mode = w[6:5];
        c.a_in   = w[4];
        c.cu_in  = w[3];
        c.b_mode = w[2];
        c.b_in   = w[1];
        c.cl_in  = w[0];
        return c;
    endfunction

    function automatic logic [7:0] cfg_to_word(input port_cfg_t c);
        return {1'b1, c};
    endfunction

    function automatic logic [PORT_W-1:0] group_oe(input logic is_in);
        return {PORT_W{~is_in}};
    endfunction

endpackage

// File: rtl/pio_bus_if.sv
module pio_bus_if
    import pio_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            cs_n,
    input  logic            wr_n,
    input  logic [1:0]      addr,
    output logic [NREG-1:0] reg_stb
);

    logic wr_n_q;
    logic commit;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_n_q <= 1'b1;
        end else begin
            wr_n_q <= wr_n;
        end
    end

    // Rising write strobe seen while the block is selected
    assign commit = !cs_n && wr_n && !wr_n_q;

    for (genvar g = 0; g < NREG; g++) begin : g_stb
        assign reg_stb[g] = commit && (addr == 2'(g));
    end

endmodule

// File: rtl/pio_ctrl_reg.sv
module pio_ctrl_reg
    import pio_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        stb,
    input  logic [7:0]  wdata,
    output port_cfg_t   cfg,
    output logic        mode_wr,
    output bit_cmd_t    bcmd
);

    assign mode_wr  = stb &&  wdata[7];
    assign bcmd.en  = stb && !wdata[7];
    assign bcmd.idx = wdata[BIT_IDX_W:1];
    assign bcmd.val = wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= cfg_from_word(CFG_RESET_WORD);
        end else if (mode_wr) begin
            cfg <= cfg_from_word(wdata);
        end
    end

endmodule

// File: rtl/pio_out_reg.sv
module pio_out_reg
    import pio_pkg::*;
#(
    parameter int W       = 8,
    parameter bit BIT_OPS = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         ld,
    input  logic [W-1:0] d,
    input  bit_cmd_t     bcmd,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (clr) begin
            q <= '0;
        end else if (ld) begin
            q <= d;
        end else if (BIT_OPS && bcmd.en) begin
            q[bcmd.idx] <= bcmd.val;
        end
    end

endmodule

// File: rtl/pio_in_sync.sv
module pio_in_sync #(
    parameter int W      = 8,
    parameter int STAGES = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pins,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg <= '0;
        end else begin
            stg[0] <= pins;
            for (int s = 1; s < STAGES; s++) begin
                stg[s] <= stg[s-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/pio_top.sv
module pio_top
    import pio_pkg::*;
#(
    parameter int SAMPLE_STAGES = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cs_n,
    input  logic       rd_n,
    input  logic       wr_n,
    input  logic [1:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic [7:0] pa_in,
    output logic [7:0] pa_out,
    output logic [7:0] pa_oe,
    input  logic [7:0] pb_in,
    output logic [7:0] pb_out,
    output logic [7:0] pb_oe,
    input  logic [7:0] pc_in,
    output logic [7:0] pc_out,
    output logic [7:0] pc_oe
);

    logic [NREG-1:0]   reg_stb;
    port_cfg_t         cfg;
    logic              mode_wr;
    bit_cmd_t          bcmd;

    logic [PORT_W-1:0] pins_in  [NPORT];
    logic [PORT_W-1:0] pins_out [NPORT];
    logic [PORT_W-1:0] oe_v     [NPORT];
    logic [PORT_W-1:0] samp     [NPORT];
    logic [PORT_W-1:0] view     [NPORT];

    pio_bus_if u_bus (
        .clk     (clk),
        .rst     (rst),
        .cs_n    (cs_n),
        .wr_n    (wr_n),
        .addr    (addr),
        .reg_stb (reg_stb)
    );

    pio_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .stb     (reg_stb[SEL_CTRL]),
        .wdata   (wdata),
        .cfg     (cfg),
        .mode_wr (mode_wr),
        .bcmd    (bcmd)
    );

    assign pins_in[SEL_A] = pa_in;
    assign pins_in[SEL_B] = pb_in;
    assign pins_in[SEL_C] = pc_in;

    assign oe_v[SEL_A] = group_oe(cfg.a_in);
    assign oe_v[SEL_B] = group_oe(cfg.b_in);
    assign oe_v[SEL_C] = {group_oe(cfg.cu_in)[HALF_W-1:0], group_oe(cfg.cl_in)[HALF_W-1:0]};

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        pio_in_sync #(
            .W      (PORT_W),
            .STAGES (SAMPLE_STAGES)
        ) u_in (
            .clk  (clk),
            .rst  (rst),
            .pins (pins_in[p]),
            .q    (samp[p])
        );

        pio_out_reg #(
            .W       (PORT_W),
            .BIT_OPS ((p == int'(SEL_C)) ? 1'b1 : 1'b0)
        ) u_out (
            .clk  (clk),
            .rst  (rst),
            .clr  (mode_wr),
            .ld   (reg_stb[p]),
            .d    (wdata),
            .bcmd (bcmd),
            .q    (pins_out[p])
        );

        // Per-bit merge: driven bits read the register, others read the pins
        assign view[p] = (pins_out[p] & oe_v[p]) | (samp[p] & ~oe_v[p]);
    end

    assign pa_out = pins_out[SEL_A];
    assign pb_out = pins_out[SEL_B];
    assign pc_out = pins_out[SEL_C];
    assign pa_oe  = oe_v[SEL_A];
    assign pb_oe  = oe_v[SEL_B];
    assign pc_oe  = oe_v[SEL_C];

    always_comb begin
        rdata = '0;
        if (!cs_n && !rd_n) begin
            case (reg_sel_e'(addr))
                SEL_A:    rdata = view[SEL_A];
                SEL_B:    rdata = view[SEL_B];
                SEL_C:    rdata = view[SEL_C];
                default:  rdata = cfg_to_word(cfg);
            endcase
        end
    end

endmodule

// File: rtl/pio_checker.sv
module pio_checker (
    input logic       clk,
    input logic       rst,
    input logic       cs_n,
    input logic       rd_n,
    input logic       wr_n,
    input logic [1:0] addr,
    input logic [7:0] wdata,
    input logic [7:0] rdata,
    input logic [7:0] pa_out,
    input logic [7:0] pa_oe,
    input logic [7:0] pb_out,
    input logic [7:0] pb_oe,
    input logic [7:0] pc_out,
    input logic [7:0] pc_oe
);

    logic wr_seen_q;
    logic wr_edge;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_seen_q <= 1'b1;
        end else begin
            wr_seen_q <= wr_n;
        end
    end

    assign wr_edge = !cs_n && wr_n && !wr_seen_q;

    // R3: drive enables are uniform per group and per C nibble
    assert_oe_uniform_R3: assert property (@(posedge clk) disable iff (rst)
        (pa_oe == 8'h00 || pa_oe == 8'hFF) &&
        (pb_oe == 8'h00 || pb_oe == 8'hFF) &&
        (pc_oe[7:4] == 4'h0 || pc_oe[7:4] == 4'hF) &&
        (pc_oe[3:0] == 4'h0 || pc_oe[3:0] == 4'hF));

    // R4: configuration word zeroes every output register
    assert_cfg_clears_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_edge && addr == 2'd3 && wdata[7]) |=>
        (pa_out == 8'h00 && pb_out == 8'h00 && pc_out == 8'h00));

    // R5: bit command moves at most one C bit and leaves A and B alone
    assert_bit_cmd_single_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_edge && addr == 2'd3 && !wdata[7]) |=>
        ($countones(pc_out ^ $past(pc_out)) <= 1 &&
         $stable(pa_out) && $stable(pb_out) &&
         $stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe)));

    // R8: without a committed write, pin state holds
    assert_no_commit_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !wr_edge |=>
        ($stable(pa_out) && $stable(pb_out) && $stable(pc_out) &&
         $stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe)));

    // R10: read bus is quiet outside a selected read
    assert_idle_bus_R10: assert property (@(posedge clk) disable iff (rst)
        (cs_n || rd_n) |-> rdata == 8'h00);

endmodule

bind pio_top pio_checker u_chk (
    .clk    (clk),
    .rst    (rst),
    .cs_n   (cs_n),
    .rd_n   (rd_n),
    .wr_n   (wr_n),
    .addr   (addr),
    .wdata  (wdata),
    .rdata  (rdata),
    .pa_out (pa_out),
    .pa_oe  (pa_oe),
    .pb_out (pb_out),
    .pb_oe  (pb_oe),
    .pc_out (pc_out),
    .pc_oe  (pc_oe)
);

// File: tb/sim_pio_top.sv
module sim_pio_top;

    localparam int CLK_PERIOD = 10;
    localparam int STAGES     = 1;
    localparam int WATCHDOG   = 20000;

    localparam logic [2:0] OP_WR  = 3'd0;
    localparam logic [2:0] OP_RD  = 3'd1;
    localparam logic [2:0] OP_PIN = 3'd2;
    localparam logic [2:0] OP_OUT = 3'd3;
    localparam logic [2:0] OP_OE  = 3'd4;

    // {op, index, data, expected, requirement number}
    localparam int NVEC = 40;
    localparam logic [24:0] VEC [NVEC] = '{
        {OP_WR,  2'd3, 8'h80, 8'h00, 4'd3},  // R3 all outputs
        {OP_OE,  2'd0, 8'h00, 8'hFF, 4'd3},
        {OP_OE,  2'd1, 8'h00, 8'hFF, 4'd3},
        {OP_OE,  2'd2, 8'h00, 8'hFF, 4'd3},
        {OP_RD,  2'd3, 8'h00, 8'h80, 4'd9},  // R9 readback
        {OP_WR,  2'd0, 8'h55, 8'h00, 4'd2},  // R2 address map
        {OP_WR,  2'd1, 8'hAA, 8'h00, 4'd2},
        {OP_WR,  2'd2, 8'h3C, 8'h00, 4'd2},
        {OP_OUT, 2'd0, 8'h00, 8'h55, 4'd2},
        {OP_OUT, 2'd1, 8'h00, 8'hAA, 4'd2},
        {OP_OUT, 2'd2, 8'h00, 8'h3C, 4'd2},
        {OP_RD,  2'd0, 8'h00, 8'h55, 4'd6},  // R6 output reads register
        {OP_WR,  2'd3, 8'h0F, 8'h00, 4'd5},  // R5 set bit 7
        {OP_OUT, 2'd2, 8'h00, 8'hBC, 4'd5},
        {OP_WR,  2'd3, 8'h04, 8'h00, 4'd5},  // R5 clear bit 2
        {OP_OUT, 2'd2, 8'h00, 8'hB8, 4'd5},
        {OP_OUT, 2'd0, 8'h00, 8'h55, 4'd5},
        {OP_RD,  2'd3, 8'h00, 8'h80, 4'd5},
        {OP_WR,  2'd3, 8'h88, 8'h00, 4'd4},  // R4 clear on config
        {OP_OUT, 2'd0, 8'h00, 8'h00, 4'd4},
        {OP_OUT, 2'd1, 8'h00, 8'h00, 4'd4},
        {OP_OUT, 2'd2, 8'h00, 8'h00, 4'd4},
        {OP_OE,  2'd2, 8'h00, 8'h0F, 4'd3},
        {OP_PIN, 2'd2, 8'hA7, 8'h00, 4'd7},  // R7 nibble merge
        {OP_RD,  2'd2, 8'h00, 8'hA0, 4'd7},
        {OP_WR,  2'd2, 8'h06, 8'h00, 4'd7},
        {OP_RD,  2'd2, 8'h00, 8'hA6, 4'd7},
        {OP_WR,  2'd3, 8'h92, 8'h00, 4'd3},
        {OP_OE,  2'd0, 8'h00, 8'h00, 4'd3},
        {OP_OE,  2'd1, 8'h00, 8'h00, 4'd3},
        {OP_PIN, 2'd0, 8'h3E, 8'h00, 4'd6},  // R6 input reads pins
        {OP_RD,  2'd0, 8'h00, 8'h3E, 4'd6},
        {OP_PIN, 2'd1, 8'h71, 8'h00, 4'd6},
        {OP_RD,  2'd1, 8'h00, 8'h71, 4'd6},
        {OP_WR,  2'd3, 8'hC0, 8'h00, 4'd9},  // R9 mode 2 stored
        {OP_RD,  2'd3, 8'h00, 8'hC0, 4'd9},
        {OP_OE,  2'd0, 8'h00, 8'hFF, 4'd9},
        {OP_WR,  2'd3, 8'hE5, 8'h00, 4'd9},
        {OP_RD,  2'd3, 8'h00, 8'hE5, 4'd9},
        {OP_OE,  2'd2, 8'h00, 8'hF0, 4'd3}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1;
    logic       rd_n = 1'b1;
    logic       wr_n = 1'b1;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [7:0] pa_in = 8'h00;
    logic [7:0] pb_in = 8'h00;
    logic [7:0] pc_in = 8'h00;
    logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [24:0] v;
    logic [7:0]  got;

    pio_top #(.SAMPLE_STAGES(STAGES)) u0 (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .wdata(wdata), .rdata(rdata),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input int req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d actual %02h expected %02h", req, act, exp);
        end
    endtask

    // Select, strobe low, strobe high (commit edge), deselect
    task automatic bus_write(input logic [1:0] a, input logic [7:0] d, input logic sel_at_rise);
        @(negedge clk);
        cs_n = 1'b0; addr = a; wdata = d; wr_n = 1'b0;
        @(negedge clk);
        cs_n = !sel_at_rise;
        wr_n = 1'b1;
        @(negedge clk);
        cs_n = 1'b1;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; addr = a;
        #(CLK_PERIOD/4);
        d = rdata;
        @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b1;
    endtask

    task automatic set_pins(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        case (a)
            2'd0:    pa_in = d;
            2'd1:    pb_in = d;
            default: pc_in = d;
        endcase
        repeat (STAGES + 2) @(negedge clk);
    endtask

    function automatic logic [7:0] pick(input logic [1:0] a, input logic [7:0] x0,
                                        input logic [7:0] x1, input logic [7:0] x2);
        return (a == 2'd0) ? x0 : (a == 2'd1) ? x1 : x2;
    endfunction

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG) begin
                errors++;
                $display("FAIL watchdog expired");
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state held during reset
        check(1, pa_out | pb_out | pc_out, 8'h00);
        check(1, pa_oe | pb_oe | pc_oe, 8'h00);
        rst = 1'b0;
        bus_read(2'd3, got);
        check(1, got, 8'h9B);
        check(1, pa_oe | pb_oe | pc_oe, 8'h00);

        for (int i = 0; i < NVEC; i++) begin
            v = VEC[i];
            case (v[24:22])
                OP_WR:  bus_write(v[21:20], v[19:12], 1'b1);
                OP_RD: begin
                    bus_read(v[21:20], got);
                    check(int'(v[3:0]), got, v[11:4]);
                end
                OP_PIN: set_pins(v[21:20], v[19:12]);
                OP_OUT: begin
                    @(negedge clk);
                    check(int'(v[3:0]), pick(v[21:20], pa_out, pb_out, pc_out), v[11:4]);
                end
                default: begin
                    @(negedge clk);
                    check(int'(v[3:0]), pick(v[21:20], pa_oe, pb_oe, pc_oe), v[11:4]);
                end
            endcase
        end

        // R8: strobe rising with select high is ignored
        bus_write(2'd0, 8'h5A, 1'b1);
        @(negedge clk);
        check(8, pa_out, 8'h5A);
        bus_write(2'd0, 8'hC3, 1'b0);
        @(negedge clk);
        check(8, pa_out, 8'h5A);
        bus_write(2'd3, 8'h80, 1'b0);
        @(negedge clk);
        check(8, pa_out, 8'h5A);
        check(8, pb_oe, 8'hFF);

        // R10: selected but no read strobe gives zero
        @(negedge clk);
        cs_n = 1'b0; addr = 2'd3;
        #(CLK_PERIOD/4);
        check(10, rdata, 8'h00);
        @(negedge clk);
        cs_n = 1'b1;

        // R1: reset in mid-run restores the power-on state
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check(1, pa_out | pb_out | pc_out, 8'h00);
        check(1, pa_oe | pb_oe | pc_oe, 8'h00);
        bus_read(2'd3, got);
        check(1, got, 8'h9B);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule